// File: doc/BRIEF.md
# Direct Timing Pulse Generator

This block turns each channel's threshold-comparator flag and peak-found flag into one dedicated timing output per channel. A single mode setting, shared by all channels, picks how that output pulse is formed. In time-over-threshold mode the pulse lasts as long as the comparator reports the signal above threshold. In time-to-peak mode the pulse opens at the upward threshold crossing and closes when the peak-found flag arrives. The peak-found edge is where the timing is taken, because it shows far less amplitude-dependent walk than a threshold edge.

A free-running 6-bit coarse counter runs on the timing clock. When a channel's pulse closes, the counter value is captured into that channel's timestamp field and a one-cycle valid strobe is raised. If the threshold falls before the peak is found in time-to-peak mode, the pulse still closes and the channel raises an error flag. A requested mode change takes effect only at a clock edge where every channel is idle, so a pulse in progress never changes its definition. All inputs are taken to be synchronous to the clock. Interpolation below one clock period is not part of this block.

Top module: `direct_timing_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, every timing output, error flag and valid strobe is 0, the active mode reads 0 (time-over-threshold), and the coarse counter holds 0.
- R2: In time-over-threshold mode (active mode 0), a channel's timing output goes high on the clock edge that first samples its threshold flag high after a low sample, and goes low on the edge that samples the threshold flag low.
- R3: In time-to-peak mode (active mode 1), a channel's timing output goes high on the same rising-crossing edge as in R2 and goes low on the first later edge that samples peak-found high, with the error flag left at 0.
- R4: In time-to-peak mode, if the threshold flag is sampled low before peak-found is seen, the pulse closes on that edge and the channel's error flag goes to 1; it stays at 1 until that channel's next pulse starts.
- R5: A new pulse needs a low-to-high transition of the threshold flag: holding the threshold flag high after a pulse has closed does not open another one, and peak-found on an idle channel has no effect.
- R6: The coarse counter starts from 0 after reset, adds one on every clock and wraps modulo 64. On the edge where a pulse closes, the channel's 6-bit timestamp field (bits 6*i+5 down to 6*i for channel i) takes the counter value held just before that edge, and its valid strobe is high for exactly the following cycle.
- R7: The requested mode (0 = time-over-threshold, 1 = time-to-peak) is loaded into the active mode only at edges where no channel's pulse is open; while any pulse is open the active mode does not change.
- R8: Channels are independent: pulses on several channels may overlap, and each closes and timestamps on its own inputs only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 1 | Requested pulse definition: 0 time-over-threshold, 1 time-to-peak |
| thr_i | input | NCH | Per-channel threshold comparator flag |
| pk_i | input | NCH | Per-channel peak-found flag |
| tmark_o | output | NCH | Per-channel timing pulse |
| err_o | output | NCH | Per-channel early-threshold-drop error flag |
| stamp_o | output | NCH*6 | Per-channel coarse timestamp captured at pulse end |
| stamp_vld_o | output | NCH | One-cycle strobe per channel when its timestamp updates |
| mode_o | output | 1 | Pulse definition currently in force |

## Verification
The assertions assume the comparator and peak-found flags are already synchronous to the clock, so each sampled level is taken as the detector's decision for that cycle, and that peak-found can be high while the threshold flag is high. The stimulus changes every input only on the falling clock edge, raises peak-found only while a pulse is open or to probe the idle case on purpose, and makes mode requests both during open pulses and during idle gaps so the loading rule is seen from both sides.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_BUSY = 1'b1
  } ch_state_e;

  typedef enum logic {
    MODE_TOT = 1'b0,
    MODE_TTP = 1'b1
  } tmode_e;
endpackage

// File: rtl/dt_coarse_cnt.sv
module dt_coarse_cnt #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dt_mode_ctl.sv
module dt_mode_ctl
  import dt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_req,
  input  logic all_idle,
  output logic mode_o
);
  tmode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst)           mode_q <= MODE_TOT;
    else if (all_idle) mode_q <= tmode_e'(mode_req);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/dt_chan.sv
module dt_chan
  import dt_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode,
  input  logic          thr,
  input  logic          pk,
  input  logic [CW-1:0] cnt,
  output logic          busy_o,
  output logic          err_o,
  output logic [CW-1:0] stamp_o,
  output logic          vld_o
);
  ch_state_e     state;
  logic          thr_q;
  logic          close_now;
  logic          close_err;

  always_comb begin
    close_now = 1'b0;
    close_err = 1'b0;
    if (state == CH_BUSY) begin
      if (tmode_e'(mode) == MODE_TTP) begin
        if (pk) begin
          close_now = 1'b1;
        end else if (!thr) begin
          close_now = 1'b1;
          close_err = 1'b1;
        end
      end else if (!thr) begin
        close_now = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= CH_IDLE;
      thr_q   <= 1'b0;
      err_o   <= 1'b0;
      stamp_o <= '0;
      vld_o   <= 1'b0;
    end else begin
      thr_q <= thr;
      vld_o <= close_now;
      if (state == CH_IDLE) begin
        if (thr && !thr_q) begin
          state <= CH_BUSY;
          err_o <= 1'b0;
        end
      end else if (close_now) begin
        state   <= CH_IDLE;
        err_o   <= close_err;
        stamp_o <= cnt;
      end
    end
  end

  assign busy_o = (state == CH_BUSY);
endmodule

// File: rtl/direct_timing_gen.sv
module direct_timing_gen #(
  parameter int NCH = 4,
  parameter int CW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_req,
  input  logic [NCH-1:0]    thr_i,
  input  logic [NCH-1:0]    pk_i,
  output logic [NCH-1:0]    tmark_o,
  output logic [NCH-1:0]    err_o,
  output logic [NCH*CW-1:0] stamp_o,
  output logic [NCH-1:0]    stamp_vld_o,
  output logic              mode_o
);
  logic [CW-1:0] coarse_cnt;
  logic          all_idle;

  dt_coarse_cnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (coarse_cnt)
  );

  assign all_idle = ~|tmark_o;

  dt_mode_ctl u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode_req (mode_req),
    .all_idle (all_idle),
    .mode_o   (mode_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dt_chan #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode_o),
      .thr     (thr_i[i]),
      .pk      (pk_i[i]),
      .cnt     (coarse_cnt),
      .busy_o  (tmark_o[i]),
      .err_o   (err_o[i]),
      .stamp_o (stamp_o[i*CW +: CW]),
      .vld_o   (stamp_vld_o[i])
    );
  end
endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
  parameter int NCH = 4,
  parameter int CW  = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           mode_o,
  input logic [NCH-1:0] thr_i,
  input logic [NCH-1:0] pk_i,
  input logic [NCH-1:0] tmark_o,
  input logic [NCH-1:0] err_o,
  input logic [NCH-1:0] stamp_vld_o,
  input logic [CW-1:0]  coarse_cnt
);
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> coarse_cnt == CW'($past(coarse_cnt) + 1'b1));

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (|tmark_o) |=> $stable(mode_o));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_tot_close_r2: assert property (@(posedge clk) disable iff (rst)
      (!mode_o && tmark_o[i] && !thr_i[i]) |=> !tmark_o[i]);

    p_ttp_peak_r3: assert property (@(posedge clk) disable iff (rst)
      (mode_o && tmark_o[i] && pk_i[i]) |=> (!tmark_o[i] && !err_o[i]));

    p_ttp_early_r4: assert property (@(posedge clk) disable iff (rst)
      (mode_o && tmark_o[i] && !pk_i[i] && !thr_i[i]) |=> (!tmark_o[i] && err_o[i]));

    p_no_retrigger_r5: assert property (@(posedge clk) disable iff (rst)
      (!tmark_o[i] && !thr_i[i]) |=> !tmark_o[i]);

    p_vld_single_r6: assert property (@(posedge clk) disable iff (rst)
      stamp_vld_o[i] |=> !stamp_vld_o[i]);

    p_vld_after_close_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(stamp_vld_o[i]) |-> $fell(tmark_o[i]));
  end
endmodule

bind direct_timing_gen dt_checker #(.NCH(NCH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_o      (mode_o),
  .thr_i       (thr_i),
  .pk_i        (pk_i),
  .tmark_o     (tmark_o),
  .err_o       (err_o),
  .stamp_vld_o (stamp_vld_o),
  .coarse_cnt  (coarse_cnt)
);

// File: tb/direct_timing_gen_tb.sv
`timescale 1ns/1ps
module direct_timing_gen_tb;
  localparam int NCH = 4;
  localparam int CW  = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mode_req = 1'b0;
  logic [NCH-1:0]    thr_i = '0;
  logic [NCH-1:0]    pk_i = '0;
  logic [NCH-1:0]    tmark_o;
  logic [NCH-1:0]    err_o;
  logic [NCH*CW-1:0] stamp_o;
  logic [NCH-1:0]    stamp_vld_o;
  logic              mode_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  direct_timing_gen #(.NCH(NCH), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .mode_req(mode_req), .thr_i(thr_i), .pk_i(pk_i),
    .tmark_o(tmark_o), .err_o(err_o), .stamp_o(stamp_o),
    .stamp_vld_o(stamp_vld_o), .mode_o(mode_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int stamp_of(input int ch);
    return int'(stamp_o[ch*CW +: CW]);
  endfunction

  // Pulse on one channel in time-over-threshold mode lasting len cycles.
  task automatic tot_pulse(input int ch, input int len);
    int exp;
    thr_i[ch] = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk(tmark_o[ch] == 1'b1, "R2 open", int'(tmark_o[ch]), 1);
    end
    thr_i[ch] = 1'b0;
    exp = cyc % 64;
    @(negedge clk);
    chk(tmark_o[ch] == 1'b0, "R2 close", int'(tmark_o[ch]), 0);
    chk(stamp_vld_o[ch] == 1'b1, "R6 strobe", int'(stamp_vld_o[ch]), 1);
    chk(stamp_of(ch) == exp, "R6 stamp", stamp_of(ch), exp);
    @(negedge clk);
    chk(stamp_vld_o[ch] == 1'b0, "R6 strobe width", int'(stamp_vld_o[ch]), 0);
  endtask

  // Pulse in time-to-peak mode; early=1 drops threshold before any peak.
  task automatic ttp_pulse(input int ch, input int tpk, input bit early);
    int exp;
    thr_i[ch] = 1'b1;
    for (int k = 0; k < tpk; k++) begin
      @(negedge clk);
      chk(tmark_o[ch] == 1'b1, "R3 open", int'(tmark_o[ch]), 1);
    end
    if (early) thr_i[ch] = 1'b0;
    else       pk_i[ch] = 1'b1;
    exp = cyc % 64;
    @(negedge clk);
    pk_i[ch] = 1'b0;
    chk(tmark_o[ch] == 1'b0, early ? "R4 close" : "R3 close", int'(tmark_o[ch]), 0);
    chk(err_o[ch] == early, early ? "R4 err set" : "R3 err clear", int'(err_o[ch]), int'(early));
    chk(stamp_of(ch) == exp, "R6 stamp ttp", stamp_of(ch), exp);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(tmark_o[ch] == 1'b0, "R5 no retrigger", int'(tmark_o[ch]), 0);
      chk(err_o[ch] == early, "R4 err hold", int'(err_o[ch]), int'(early));
    end
    thr_i[ch] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int exp0, exp2;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(tmark_o == '0, "R1 tmark", int'(tmark_o), 0);
    chk(err_o == '0, "R1 err", int'(err_o), 0);
    chk(stamp_vld_o == '0, "R1 vld", int'(stamp_vld_o), 0);
    chk(mode_o == 1'b0, "R1 mode", int'(mode_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tmark_o == '0 && stamp_vld_o == '0, "R1 after release", int'(tmark_o), 0);
    // R1/R6 counter origin: pulse closing on known cycle
    tot_pulse(0, 1);

    // R2 sweep: every channel, lengths 1..8
    for (int ch = 0; ch < NCH; ch++)
      for (int len = 1; len <= 8; len++) begin
        tot_pulse(ch, len);
        @(negedge clk);
      end
    // R6 wrap: long pulse crossing the counter wrap
    tot_pulse(3, 70);

    // R7: request TtP while a pulse is open
    thr_i[1] = 1'b1;
    @(negedge clk);
    mode_req = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(mode_o == 1'b0, "R7 hold while busy", int'(mode_o), 0);
    end
    thr_i[1] = 1'b0;
    @(negedge clk);
    chk(mode_o == 1'b0, "R7 close edge", int'(mode_o), 0);
    @(negedge clk);
    chk(mode_o == 1'b1, "R7 load when idle", int'(mode_o), 1);

    // R5: peak on idle channel ignored
    pk_i = '1;
    repeat (3) begin
      @(negedge clk);
      chk(tmark_o == '0 && stamp_vld_o == '0, "R5 idle peak", int'(tmark_o), 0);
    end
    pk_i = '0;
    @(negedge clk);

    // R3/R4 sweep
    for (int ch = 0; ch < NCH; ch++)
      for (int t = 1; t <= 6; t++) begin
        ttp_pulse(ch, t, 1'b0);
        ttp_pulse(ch, t, 1'b1);
        // R4: err cleared at next start
        thr_i[ch] = 1'b1;
        @(negedge clk);
        chk(err_o[ch] == 1'b0, "R4 err clear on start", int'(err_o[ch]), 0);
        pk_i[ch] = 1'b1;
        @(negedge clk);
        pk_i[ch] = 1'b0;
        thr_i[ch] = 1'b0;
        @(negedge clk);
      end

    // R8: overlapping pulses in TtP, ch0 peaks early, ch2 later
    thr_i[0] = 1'b1; thr_i[2] = 1'b1;
    repeat (2) @(negedge clk);
    pk_i[0] = 1'b1; exp0 = cyc % 64;
    @(negedge clk);
    pk_i[0] = 1'b0;
    chk(tmark_o[0] == 1'b0, "R8 ch0 closed", int'(tmark_o[0]), 0);
    chk(tmark_o[2] == 1'b1, "R8 ch2 still open", int'(tmark_o[2]), 1);
    chk(stamp_of(0) == exp0, "R8 ch0 stamp", stamp_of(0), exp0);
    repeat (2) @(negedge clk);
    pk_i[2] = 1'b1; exp2 = cyc % 64;
    @(negedge clk);
    pk_i[2] = 1'b0;
    chk(tmark_o[2] == 1'b0, "R8 ch2 closed", int'(tmark_o[2]), 0);
    chk(stamp_of(2) == exp2, "R8 ch2 stamp", stamp_of(2), exp2);
    chk(stamp_of(0) == exp0, "R8 ch0 stamp kept", stamp_of(0), exp0);
    thr_i = '0;
    mode_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(mode_o == 1'b0, "R7 back to ToT", int'(mode_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule